// File: doc/BRIEF.md
# Programmable Coincidence Final Trigger

This block takes one trigger line from each detector layer and decides whether enough layers fired together to count as an event. Every layer line is first synchronised to the block clock. Each rising edge on a line then opens a coincidence window of programmable length. Layers that a host-written mask excludes are dropped. The block counts the layers whose windows are open and compares that number against a programmable threshold. When the count first reaches the threshold, a one-cycle trigger pulse is produced.

The final trigger raises an attention line toward the host. While that line is pending and the veto gate is enabled, further final triggers are suppressed. The ungated trigger is still produced and counted. On every final trigger, the block captures which layers were in their window and which "at least k layers" levels were met, so the host can read them back. Rate scalers count the rising edges of each multiplicity level and of the ungated trigger. A plain single-cycle register port gives the host access to configuration, captured state and scalers.

Top module: `coinc_final_trigger`

## Requirements
- R1: After reset, trig_out, raw_trig and lam are 0 and every scaler reads 0. The layer mask reads 0 and the threshold reads 1. The window reads 1 and the control register reads 1 (veto gate on, nothing pending).
- R2: Let the multiplicity be the number of unmasked layers whose window is open. A coincidence holds while the multiplicity is at least the threshold. A write of 0 to the threshold register (address 1) stores 1.
- R3: A layer whose bit is set in the mask register (address 0, bit i for layer i) never counts toward the multiplicity.
- R4: A synchronised rising edge on a layer keeps that layer's window open for exactly W cycles, where W is held in address 2, bits 3:0. Two layers whose inputs rise d cycles apart therefore coincide only when d < W. A write of 0 to the window register stores 1.
- R5: The trigger pulses for one cycle on the rising edge of the coincidence. It does not fire again while the coincidence stays true, even when the multiplicity grows, and it can fire again once the coincidence has dropped.
- R6: An input first sampled high at clock edge e0 shows raw_trig and trig_out high after edge e3, and low again after edge e4.
- R7: A final trigger sets lam. Writing address 3 with bit 1 set clears lam. Bit 0 of that register is the veto gate. While lam and the gate are both 1, trig_out stays 0. Reading address 3 returns the gate in bit 0 and lam in bit 2.
- R8: The ungated trigger scaler (address 6, 24 bits) counts every raw_trig pulse, vetoed ones included.
- R9: Combination scaler k sits at address 16+k and is 16 bits wide. It counts rising edges of "multiplicity at least k+1" and saturates at 65535.
- R10: Any write to a scaler address clears that scaler to 0.
- R11: On each final trigger (never on a vetoed one), address 4 captures the open-window state of every layer. Address 5 captures the combination levels, with bit k set when the multiplicity is at least k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| layer_in | input | NLAYER | Asynchronous per-layer trigger lines |
| host_we | input | 1 | Register write strobe, one cycle |
| host_addr | input | 5 | Register address |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data for host_addr, combinational |
| trig_out | output | 1 | Final (gated) trigger pulse |
| raw_trig | output | 1 | Ungated trigger pulse |
| lam | output | 1 | Host attention request |

## Verification
The assertions assume the host never writes the window register with anything but a 4-bit field. They also assume layer lines are quiet at reset release and that the host writes one register per cycle. The bench drives layer lines one full cycle at a time on the falling clock edge and leaves at least 24 idle cycles after each event, so every window has closed before the next stimulus. Random masks, thresholds (some beyond the layer count, some zero), windows and layer subsets are drawn from a fixed seed. Directed cases cover the window edge, growth of the multiplicity, the veto and scaler saturation.

// File: rtl/ftrig_pkg.sv
package ftrig_pkg;
  localparam int REG_MASK   = 0;
  localparam int REG_THRESH = 1;
  localparam int REG_WIN    = 2;
  localparam int REG_CTRL   = 3;
  localparam int REG_LLAYER = 4;
  localparam int REG_LCOMBO = 5;
  localparam int REG_TSCAL  = 6;
  localparam int COMBO_BASE = 16;

  // number of set bits in a word
  function automatic int unsigned ones32(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += {31'b0, v[i]};
    return n;
  endfunction

  // zero is not a legal setting for window or threshold: map it to one
  function automatic logic [7:0] nonzero8(input logic [7:0] v);
    return (v == 8'd0) ? 8'd1 : v;
  endfunction
endpackage

// File: rtl/ftrig_layer_cond.sv
module ftrig_layer_cond #(
  parameter int NLAYER = 8,
  parameter int WIN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLAYER-1:0] layer_in,
  input  logic [WIN_W-1:0]  win,
  output logic [NLAYER-1:0] rise,
  output logic [NLAYER-1:0] active
);
  for (genvar i = 0; i < NLAYER; i++) begin : g_layer
    logic s1, s2, s3;
    logic [WIN_W-1:0] left;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0; left <= '0;
      end else begin
        s1 <= layer_in[i];
        s2 <= s1;
        s3 <= s2;
        if (s2 && !s3)        left <= win;
        else if (left != '0)  left <= left - 1'b1;
      end
    end
    assign rise[i]   = s2 & ~s3;
    assign active[i] = (left != '0);
  end
endmodule

// File: rtl/ftrig_coinc_core.sv
module ftrig_coinc_core #(
  parameter int NLAYER = 8,
  parameter int CNT_W  = $clog2(NLAYER + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLAYER-1:0] active,
  input  logic [NLAYER-1:0] mask,
  input  logic [CNT_W-1:0]  thresh,
  input  logic              veto_en,
  input  logic              ack,
  output logic [NLAYER-1:0] combo,
  output logic [NLAYER-1:0] combo_rise,
  output logic              fire_now,
  output logic              raw_trig,
  output logic              trig_out,
  output logic              lam
);
  import ftrig_pkg::*;

  logic [CNT_W-1:0]  mult;
  logic              cond, cond_q, raw_edge, blocked;
  logic [NLAYER-1:0] combo_q;

  assign mult = CNT_W'(ones32(32'(active & ~mask)));
  assign cond = (mult >= thresh);

  for (genvar k = 0; k < NLAYER; k++) begin : g_combo
    assign combo[k] = (mult >= CNT_W'(k + 1));
  end

  assign combo_rise = combo & ~combo_q;
  assign raw_edge   = cond & ~cond_q;
  assign blocked    = lam & veto_en;
  assign fire_now   = raw_edge & ~blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q   <= 1'b0;
      combo_q  <= '0;
      raw_trig <= 1'b0;
      trig_out <= 1'b0;
      lam      <= 1'b0;
    end else begin
      cond_q   <= cond;
      combo_q  <= combo;
      raw_trig <= raw_edge;
      trig_out <= fire_now;
      if (fire_now) lam <= 1'b1;
      else if (ack) lam <= 1'b0;
    end
  end
endmodule

// File: rtl/ftrig_scaler.sv
module ftrig_scaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr)                 cnt <= '0;
    else if (inc && (cnt != '1))  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/coinc_final_trigger.sv
module coinc_final_trigger #(
  parameter int NLAYER  = 8,
  parameter int ADDR_W  = 5,
  parameter int CSCAL_W = 16,
  parameter int TSCAL_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLAYER-1:0] layer_in,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              trig_out,
  output logic              raw_trig,
  output logic              lam
);
  import ftrig_pkg::*;

  localparam int WIN_W = 4;
  localparam int CNT_W = $clog2(NLAYER + 1);

  logic [NLAYER-1:0]  mask_q;
  logic [CNT_W-1:0]   thresh_q;
  logic [WIN_W-1:0]   win_q;
  logic               veto_en_q;
  logic [NLAYER-1:0]  lat_layer_q, lat_combo_q;
  logic [NLAYER-1:0]  rise, active, combo, combo_rise;
  logic               fire_now, ack;
  logic [TSCAL_W-1:0] tscal;
  logic [CSCAL_W-1:0] cscal [NLAYER];
  logic [NLAYER-1:0]  cclr;
  logic               tclr;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int r);
    return host_we && (a == ADDR_W'(r));
  endfunction

  assign ack  = hit(host_addr, REG_CTRL) && host_wdata[1];
  assign tclr = hit(host_addr, REG_TSCAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      thresh_q  <= CNT_W'(1);
      win_q     <= WIN_W'(1);
      veto_en_q <= 1'b1;
    end else begin
      if (hit(host_addr, REG_MASK))   mask_q    <= host_wdata[NLAYER-1:0];
      if (hit(host_addr, REG_THRESH))
        thresh_q <= CNT_W'(nonzero8({{(8-CNT_W){1'b0}}, host_wdata[CNT_W-1:0]}));
      if (hit(host_addr, REG_WIN))
        win_q    <= WIN_W'(nonzero8({4'b0, host_wdata[WIN_W-1:0]}));
      if (hit(host_addr, REG_CTRL))   veto_en_q <= host_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_layer_q <= '0;
      lat_combo_q <= '0;
    end else if (fire_now) begin
      lat_layer_q <= active;
      lat_combo_q <= combo;
    end
  end

  ftrig_layer_cond #(.NLAYER(NLAYER), .WIN_W(WIN_W)) u_cond (
    .clk(clk), .rst_n(rst_n), .layer_in(layer_in), .win(win_q),
    .rise(rise), .active(active)
  );

  ftrig_coinc_core #(.NLAYER(NLAYER), .CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .active(active), .mask(mask_q),
    .thresh(thresh_q), .veto_en(veto_en_q), .ack(ack),
    .combo(combo), .combo_rise(combo_rise), .fire_now(fire_now),
    .raw_trig(raw_trig), .trig_out(trig_out), .lam(lam)
  );

  ftrig_scaler #(.W(TSCAL_W)) u_tscal (
    .clk(clk), .rst_n(rst_n), .inc(raw_trig), .clr(tclr), .cnt(tscal)
  );

  for (genvar k = 0; k < NLAYER; k++) begin : g_cscal
    assign cclr[k] = hit(host_addr, COMBO_BASE + k);
    ftrig_scaler #(.W(CSCAL_W)) u_cs (
      .clk(clk), .rst_n(rst_n), .inc(combo_rise[k]), .clr(cclr[k]), .cnt(cscal[k])
    );
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == ADDR_W'(REG_MASK))   host_rdata = 32'(mask_q);
    if (host_addr == ADDR_W'(REG_THRESH)) host_rdata = 32'(thresh_q);
    if (host_addr == ADDR_W'(REG_WIN))    host_rdata = 32'(win_q);
    if (host_addr == ADDR_W'(REG_CTRL))   host_rdata = {29'b0, lam, 1'b0, veto_en_q};
    if (host_addr == ADDR_W'(REG_LLAYER)) host_rdata = 32'(lat_layer_q);
    if (host_addr == ADDR_W'(REG_LCOMBO)) host_rdata = 32'(lat_combo_q);
    if (host_addr == ADDR_W'(REG_TSCAL))  host_rdata = 32'(tscal);
    for (int k = 0; k < NLAYER; k++)
      if (host_addr == ADDR_W'(COMBO_BASE + k)) host_rdata = 32'(cscal[k]);
  end
endmodule

// File: rtl/ftrig_checker.sv
module ftrig_checker #(
  parameter int ADDR_W  = 5,
  parameter int TSCAL_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_out,
  input logic              raw_trig,
  input logic              lam,
  input logic              veto_en,
  input logic [3:0]        win,
  input logic [TSCAL_W-1:0] tscal,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr
);
  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |=> !trig_out); // R5
  AST_TRIG_HAS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> raw_trig); // R8
  AST_LAM_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> lam); // R7
  AST_VETO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lam && veto_en) |=> !trig_out); // R7
  AST_WIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    win != 4'd0); // R4
  AST_TSCAL_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_we && host_addr == ADDR_W'(ftrig_pkg::REG_TSCAL)) |=> tscal >= $past(tscal)); // R8
endmodule

bind coinc_final_trigger ftrig_checker #(.ADDR_W(ADDR_W), .TSCAL_W(TSCAL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_out(trig_out), .raw_trig(raw_trig), .lam(lam),
  .veto_en(veto_en_q), .win(win_q), .tscal(tscal),
  .host_we(host_we), .host_addr(host_addr)
);

// File: tb/tb_coinc_final_trigger.sv
module tb_coinc_final_trigger;
  localparam int NL = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NL-1:0] layer_in = '0;
  logic        host_we = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        trig_out, raw_trig, lam;

  int total = 0, bad = 0, ntrig = 0;
  bit done = 0;

  always #2 clk = ~clk;

  coinc_final_trigger dut (
    .clk(clk), .rst_n(rst_n), .layer_in(layer_in), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .trig_out(trig_out), .raw_trig(raw_trig), .lam(lam)
  );

  always @(negedge clk) if (rst_n && trig_out) ntrig++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = 5'(a); host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); host_addr = 5'(a); #1; d = host_rdata;
  endtask

  task automatic pulse_pair(input logic [NL-1:0] a, input logic [NL-1:0] b, input int d);
    @(negedge clk); layer_in = a;
    @(negedge clk); layer_in = '0;
    if (d > 0) begin
      repeat (d - 1) @(negedge clk);
      layer_in = b;
      @(negedge clk); layer_in = '0;
    end
    repeat (24) @(negedge clk);
  endtask

  function automatic int pop(input logic [NL-1:0] v);
    int n = 0;
    for (int i = 0; i < NL; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic [31:0] therm(input int n);
    logic [31:0] t = '0;
    for (int i = 0; i < n; i++) t[i] = 1'b1;
    return t;
  endfunction

  task automatic clear_all();
    wr(6, 0);
    for (int k = 0; k < NL; k++) wr(16 + k, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int t0;
    int cexp [NL];
    int texp;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 trig_out", 32'(trig_out), 0);
    check("R1 raw_trig", 32'(raw_trig), 0);
    check("R1 lam", 32'(lam), 0);
    rd(0, v); check("R1 mask", v, 0);
    rd(1, v); check("R1 thresh", v, 1);
    rd(2, v); check("R1 window", v, 1);
    rd(3, v); check("R1 ctrl", v, 1);
    rd(6, v); check("R1 tscal", v, 0);
    for (int k = 0; k < NL; k++) begin rd(16 + k, v); check("R1 cscal", v, 0); end

    // R6 latency: sampled at e0, high after e3, low after e4
    wr(2, 3);
    @(negedge clk); layer_in = 8'h01;
    @(posedge clk); @(negedge clk); layer_in = '0;
    check("R6 after e0", 32'({raw_trig, trig_out}), 0);
    @(negedge clk); check("R6 after e1", 32'({raw_trig, trig_out}), 0);
    @(negedge clk); check("R6 after e2", 32'({raw_trig, trig_out}), 0);
    @(negedge clk); check("R6 after e3", 32'({raw_trig, trig_out}), 3);
    @(negedge clk); check("R6 after e4", 32'({raw_trig, trig_out}), 0);
    repeat (20) @(negedge clk);
    check("R7 lam set", 32'(lam), 1);
    wr(3, 3);
    check("R7 lam cleared by ack", 32'(lam), 0);
    rd(6, v); check("R8 tscal one", v, 1);

    // R10 clear on write
    clear_all();
    rd(6, v); check("R10 tscal cleared", v, 0);
    rd(16, v); check("R10 cscal0 cleared", v, 0);

    // R4 window boundary: W=4, thresh 2
    wr(2, 4); wr(1, 2);
    t0 = ntrig; pulse_pair(8'h01, 8'h02, 3);
    check("R4 offset W-1 coincides", 32'(ntrig - t0), 1);
    wr(3, 3);
    t0 = ntrig; pulse_pair(8'h01, 8'h02, 4);
    check("R4 offset W no coincidence", 32'(ntrig - t0), 0);
    wr(2, 0); rd(2, v); check("R4 window zero stored as one", v, 1);
    wr(1, 0); rd(1, v); check("R2 thresh zero stored as one", v, 1);

    // R5 no refire while multiplicity grows
    wr(2, 8); wr(1, 2);
    t0 = ntrig; pulse_pair(8'h03, 8'h04, 2);
    check("R5 single pulse on growth", 32'(ntrig - t0), 1);
    wr(3, 3);
    t0 = ntrig; pulse_pair(8'h03, 8'h00, 0);
    check("R5 refires after drop", 32'(ntrig - t0), 1);
    wr(3, 3);

    // R3 fully masked
    wr(0, 32'hFF); wr(1, 1);
    t0 = ntrig; pulse_pair(8'hFF, 8'h00, 0);
    check("R3 masked layers ignored", 32'(ntrig - t0), 0);
    wr(0, 0);

    // R7 R8 R11 veto
    clear_all(); wr(3, 1);
    t0 = ntrig; pulse_pair(8'h03, 8'h00, 0);
    check("R7 first fires", 32'(ntrig - t0), 1);
    pulse_pair(8'h0C, 8'h00, 0);
    check("R7 vetoed while pending", 32'(ntrig - t0), 1);
    rd(6, v); check("R8 tscal counts vetoed", v, 2);
    rd(4, v); check("R11 latch not updated on veto", v, 32'h03);
    rd(3, v); check("R7 ctrl shows lam", v, 32'h5);
    wr(3, 0);
    t0 = ntrig; pulse_pair(8'h30, 8'h00, 0);
    check("R7 gate off fires while pending", 32'(ntrig - t0), 1);
    rd(4, v); check("R11 latch updated", v, 32'h30);
    wr(3, 3);

    // R2 R3 R9 R11 random
    clear_all();
    texp = 0;
    for (int k = 0; k < NL; k++) cexp[k] = 0;
    for (int it = 0; it < 40; it++) begin
      logic [NL-1:0] sub, msk;
      int th, eff, w, p;
      bit fire;
      sub = NL'($urandom); msk = ($urandom % 3 == 0) ? NL'($urandom) : '0;
      th = $urandom % 10; eff = (th == 0) ? 1 : th; w = 1 + $urandom % 15;
      wr(0, 32'(msk)); wr(1, 32'(th)); wr(2, 32'(w));
      p = pop(sub & ~msk);
      fire = (p >= eff);
      t0 = ntrig; pulse_pair(sub, 8'h00, 0);
      check("R2 random coincidence", 32'(ntrig - t0), 32'(fire));
      check("R7 lam follows trigger", 32'(lam), 32'(fire));
      if (fire) begin
        texp++;
        rd(4, v); check("R11 latched layers", v, 32'(sub));
        rd(5, v); check("R11 latched combos", v, therm(p));
      end
      for (int k = 0; k < NL; k++) if (p > k) cexp[k]++;
      wr(3, 3);
    end
    rd(6, v); check("R8 tscal random", v, 32'(texp));
    for (int k = 0; k < NL; k++) begin rd(16 + k, v); check("R9 cscal random", v, 32'(cexp[k])); end

    // R9 saturation, R8 wide count
    wr(0, 0); wr(1, 1); wr(2, 1); wr(3, 0);
    clear_all();
    for (int i = 0; i < 65540; i++) begin
      @(negedge clk); layer_in = 8'h01;
      @(negedge clk); layer_in = '0;
    end
    repeat (10) @(negedge clk);
    rd(16, v); check("R9 cscal0 saturates", v, 32'd65535);
    rd(17, v); check("R9 cscal1 untouched", v, 0);
    rd(6, v); check("R8 tscal beyond 16 bits", v, 32'd65540);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule